// File: doc/BRIEF.md
# USB Low/Full-Speed Line Sampler

This block turns the two data lines of a low-speed or full-speed USB link into a stream of line symbols. It runs on a fixed system clock that is much faster than the bit rate. Each line passes through a two-stage synchronizer. The synchronized pair is then mapped to J, K, SE0 or SE1, using the polarity that the speed-select input picks.

While idle, the block waits for the line to read K, which marks the start of a packet. From that instant it reads the line once per bit, in the middle of each bit period. It derives every sampling instant from the start edge, a half bit, and a whole number of bit periods. The bit period is a fixed-point parameter, so widths that are not whole clock counts do not drift over a packet. The block does not re-align on later edges.

Each sampled symbol is presented downstream with a one-cycle valid strobe. An SE0 sample moves the block into its end phase. An SE0 sample followed directly by a J sample ends the packet. An SE1 sample is flagged. A packet that runs past a maximum bit count is abandoned with a timeout pulse.

Top module: `usb_line_sampler`

## Requirements
- R1: Symbol codes on `sym_code_o` are SE0=0, J=1, K=2, SE1=3. With `low_speed_i`=0, D+=1/D-=0 is J and D+=0/D-=1 is K. With `low_speed_i`=1, these two are swapped. Both lines low is SE0 and both high is SE1 in either mode.
- R2: Each line passes through two synchronizer flops before the decision logic, and every output is registered. A line value driven before clock edge k is therefore acted on at edge k+2 and shows on the outputs after that edge.
- R3: In idle, the first edge at which the synchronized symbol is K is the start instant s. `sop_o` pulses for exactly one cycle after it.
- R4: Bit n (n from 0) is sampled at edge s + floor((W/2 + n*W) / 2^FRAC_BITS). W is `BIT_FS_FX` (default 4267, about 16.67 clocks) at full speed or `BIT_LS_FX` (default 34133, about 133.3 clocks) at low speed, with FRAC_BITS=8 and W/2 rounded down. Each sample gives a one-cycle `sym_valid_o` with the sampled code.
- R5: Inside a packet the line is read only at the R4 instants. Line changes between those instants, including short glitches, do not affect any output.
- R6: An SE0 sample moves the block from the data phase to the end phase. In the end phase, a J sample directly after an SE0 sample pulses `eop_o` together with that J's `sym_valid_o`, and the block returns to idle.
- R7: After an end of packet or a timeout the block is idle. The next K starts a new packet with fresh timing and a bit count of zero.
- R8: A sample that reads SE1 pulses `se1_err_o` together with its `sym_valid_o`.
- R9: If the MAX_BITS-th sample of a packet (default 64) does not end the packet, `timeout_o` pulses together with that sample's `sym_valid_o` and the block returns to idle.
- R10: A synchronous reset clears the synchronizer stages to 0 and returns the block to idle. All strobe outputs are low after reset.
- R11: In idle, J, SE0 and SE1 produce no output of any kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System sampling clock |
| rst_i | input | 1 | Synchronous active-high reset |
| dp_i | input | 1 | D+ line, asynchronous |
| dm_i | input | 1 | D- line, asynchronous |
| low_speed_i | input | 1 | 1 selects low-speed polarity and bit width, 0 full speed |
| sym_valid_o | output | 1 | One-cycle strobe for a sampled symbol |
| sym_code_o | output | 2 | Code of the sampled symbol (valid with the strobe) |
| sop_o | output | 1 | One-cycle start-of-packet pulse |
| eop_o | output | 1 | One-cycle end-of-packet pulse |
| se1_err_o | output | 1 | One-cycle pulse when SE1 is sampled |
| timeout_o | output | 1 | One-cycle pulse when a packet exceeds the bit limit |

## Verification
A fractional accumulator that rounds wrongly or is seeded wrongly moves a strobe by one clock. That shows at the first sample of a packet, or after a few dozen bits as the error builds up. The bench compares every strobe and code against a reference model on every clock, so such a fault is caught on the first cycle where the timing differs. A wrong phase register shows as a missing or extra `eop_o` or `sop_o` within the packet it corrupts. A bit counter that is off by one moves `timeout_o` by one sample.

// File: rtl/usb_ls_pkg.sv
package usb_ls_pkg;

  typedef enum logic [1:0] {
    SYM_SE0 = 2'd0,
    SYM_J   = 2'd1,
    SYM_K   = 2'd2,
    SYM_SE1 = 2'd3
  } line_sym_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_DATA = 2'd1,
    PH_END  = 2'd2
  } phase_t;

  // Line pair to symbol; low speed swaps the polarity of J and K.
  function automatic line_sym_t decode_pair(input logic dp, input logic dm,
                                            input logic low);
    line_sym_t s;
    case ({dp, dm})
      2'b00:   s = SYM_SE0;
      2'b11:   s = SYM_SE1;
      2'b10:   s = low ? SYM_K : SYM_J;
      default: s = low ? SYM_J : SYM_K;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/usb_ls_sync.sv
module usb_ls_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i) begin
          if (rst_i) stage_q[g] <= '0;
          else       stage_q[g] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i) begin
          if (rst_i) stage_q[g] <= '0;
          else       stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/usb_ls_symmap.sv
module usb_ls_symmap
  import usb_ls_pkg::*;
(
  input  logic      dp_i,
  input  logic      dm_i,
  input  logic      low_speed_i,
  output line_sym_t sym_o
);

  always_comb sym_o = decode_pair(dp_i, dm_i, low_speed_i);

endmodule

// File: rtl/usb_ls_bittimer.sv
module usb_ls_bittimer #(
  parameter int FRAC_BITS = 8,
  parameter int CNT_W     = 16,
  localparam int ACC_W    = CNT_W + FRAC_BITS
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             start_i,
  input  logic             run_i,
  input  logic [ACC_W-1:0] width_fx_i,
  output logic             tick_o
);

  logic [CNT_W-1:0] elapsed_q;
  logic [ACC_W-1:0] target_q;

  assign tick_o = run_i && (elapsed_q >= target_q[ACC_W-1:FRAC_BITS]);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      elapsed_q <= '0;
      target_q  <= '0;
    end else if (start_i) begin
      elapsed_q <= CNT_W'(1);
      target_q  <= width_fx_i >> 1;
    end else if (run_i) begin
      elapsed_q <= elapsed_q + CNT_W'(1);
      if (tick_o) target_q <= target_q + width_fx_i;
    end else begin
      elapsed_q <= '0;
      target_q  <= '0;
    end
  end

  // R5: bit instants are at least two clocks apart, never back to back
  assert_tick_spacing_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    tick_o |=> !tick_o);

endmodule

// File: rtl/usb_line_sampler.sv
module usb_line_sampler
  import usb_ls_pkg::*;
#(
  parameter int FRAC_BITS = 8,
  parameter int BIT_FS_FX = 4267,
  parameter int BIT_LS_FX = 34133,
  parameter int MAX_BITS  = 64
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       dp_i,
  input  logic       dm_i,
  input  logic       low_speed_i,
  output logic       sym_valid_o,
  output logic [1:0] sym_code_o,
  output logic       sop_o,
  output logic       eop_o,
  output logic       se1_err_o,
  output logic       timeout_o
);

  localparam int WMAX_FX = (BIT_LS_FX > BIT_FS_FX) ? BIT_LS_FX : BIT_FS_FX;
  localparam int CNT_W   = $clog2((MAX_BITS + 2) * ((WMAX_FX >> FRAC_BITS) + 1)) + 1;
  localparam int ACC_W   = CNT_W + FRAC_BITS;
  localparam int BN_W    = $clog2(MAX_BITS + 1);
  localparam logic [ACC_W-1:0] W_FS = ACC_W'(BIT_FS_FX);
  localparam logic [ACC_W-1:0] W_LS = ACC_W'(BIT_LS_FX);
  localparam logic [BN_W-1:0]  LAST_BIT = BN_W'(MAX_BITS - 1);

  logic [1:0]       line_s;
  line_sym_t        sym_now;
  phase_t           phase_q;
  logic [BN_W-1:0]  bitnum_q;
  logic             prev_se0_q;
  logic             start, run, tick, eop_hit;
  logic [ACC_W-1:0] width_fx;

  usb_ls_sync #(.WIDTH(2), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   ({dp_i, dm_i}),
    .q_o   (line_s)
  );

  usb_ls_symmap u_map (
    .dp_i        (line_s[1]),
    .dm_i        (line_s[0]),
    .low_speed_i (low_speed_i),
    .sym_o       (sym_now)
  );

  assign width_fx = low_speed_i ? W_LS : W_FS;
  assign start    = (phase_q == PH_IDLE) && (sym_now == SYM_K);
  assign run      = (phase_q != PH_IDLE);
  assign eop_hit  = (phase_q == PH_END) && prev_se0_q && (sym_now == SYM_J);

  usb_ls_bittimer #(.FRAC_BITS(FRAC_BITS), .CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .start_i    (start),
    .run_i      (run),
    .width_fx_i (width_fx),
    .tick_o     (tick)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      phase_q     <= PH_IDLE;
      bitnum_q    <= '0;
      prev_se0_q  <= 1'b0;
      sym_valid_o <= 1'b0;
      sym_code_o  <= 2'd0;
      sop_o       <= 1'b0;
      eop_o       <= 1'b0;
      se1_err_o   <= 1'b0;
      timeout_o   <= 1'b0;
    end else begin
      sym_valid_o <= 1'b0;
      eop_o       <= 1'b0;
      se1_err_o   <= 1'b0;
      timeout_o   <= 1'b0;
      sop_o       <= start;
      if (start) begin
        phase_q    <= PH_DATA;
        bitnum_q   <= '0;
        prev_se0_q <= 1'b0;
      end else if (run && tick) begin
        sym_valid_o <= 1'b1;
        sym_code_o  <= sym_now;
        se1_err_o   <= (sym_now == SYM_SE1);
        prev_se0_q  <= (sym_now == SYM_SE0);
        bitnum_q    <= bitnum_q + BN_W'(1);
        if (eop_hit) begin
          eop_o    <= 1'b1;
          phase_q  <= PH_IDLE;
          bitnum_q <= '0;
        end else if (bitnum_q == LAST_BIT) begin
          timeout_o <= 1'b1;
          phase_q   <= PH_IDLE;
          bitnum_q  <= '0;
        end else if (phase_q == PH_DATA && sym_now == SYM_SE0) begin
          phase_q <= PH_END;
        end
      end
    end
  end

  // R3: start pulse never coincides with a sample and lasts one cycle
  assert_sop_alone_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    sop_o |-> !sym_valid_o);
  assert_sop_single_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    sop_o |=> !sop_o);
  // R6: end of packet is reported on a J sample
  assert_eop_on_j_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    eop_o |-> (sym_valid_o && sym_code_o == SYM_J));
  // R7: after end of packet the block is idle, no sample follows at once
  assert_eop_idle_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    eop_o |=> !sym_valid_o);
  // R8: error pulse only with an SE1 sample
  assert_se1_flag_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    se1_err_o |-> (sym_valid_o && sym_code_o == SYM_SE1));
  // R9: timeout rides on a sample and excludes end of packet
  assert_timeout_sample_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    timeout_o |-> (sym_valid_o && !eop_o));
  // R10: strobes are low in the cycle after reset
  assert_reset_quiet_R10: assert property (@(posedge clk_i)
    $past(rst_i) |-> !(sym_valid_o || sop_o || eop_o || timeout_o));

endmodule

// File: tb/sim_usb_line_sampler.sv
`timescale 1ns/1ps
module sim_usb_line_sampler;

  localparam int WFS  = 4267;
  localparam int WLS  = 34133;
  localparam int MAXB = 64;
  localparam int SE0 = 0, JS = 1, KS = 2, SE1 = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dp = 1'b1, dm = 1'b0, low = 1'b0;
  logic valid, sop, eop, err, tmo;
  logic [1:0] code;

  int checks = 0, errors = 0;
  bit active = 0, finished = 0;
  int n_eop = 0, n_tmo = 0, n_err = 0, n_valid = 0;

  always #2.5 clk = ~clk;

  usb_line_sampler u0 (
    .clk_i(clk), .rst_i(rst), .dp_i(dp), .dm_i(dm), .low_speed_i(low),
    .sym_valid_o(valid), .sym_code_o(code), .sop_o(sop), .eop_o(eop),
    .se1_err_o(err), .timeout_o(tmo)
  );

  // R1 polarity, as the bench understands it
  function automatic int sym_of(bit p, bit m, bit ls);
    if (!p && !m) return SE0;
    if (p && m)   return SE1;
    if (p)        return ls ? KS : JS;
    return ls ? JS : KS;
  endfunction

  // Reference model: absolute clock index, start index, sample number
  int t = 0, sop_t = 0, nb = 0, mst = 0;
  bit mprev = 0, m1p = 0, m1m = 0, m2p = 0, m2m = 0;
  bit e_val = 0, e_sop = 0, e_eop = 0, e_err = 0, e_tmo = 0;
  int e_code = 0;

  always @(posedge clk) begin
    if (rst) begin
      m1p = 0; m1m = 0; m2p = 0; m2m = 0; mst = 0; t = 0;
      e_val = 0; e_sop = 0; e_eop = 0; e_err = 0; e_tmo = 0;
    end else begin
      int s, w;
      s = sym_of(m2p, m2m, low);
      m2p = m1p; m2m = m1m; m1p = dp; m1m = dm;
      e_val = 0; e_sop = 0; e_eop = 0; e_err = 0; e_tmo = 0;
      w = low ? WLS : WFS;
      if (mst == 0) begin
        if (s == KS) begin
          mst = 1; sop_t = t; nb = 0; mprev = 0; e_sop = 1;
        end
      end else if (t == sop_t + ((w / 2 + nb * w) >> 8)) begin
        e_val = 1; e_code = s; e_err = (s == SE1);
        if (mst == 2 && mprev && s == JS) begin e_eop = 1; mst = 0; end
        else if (nb == MAXB - 1) begin e_tmo = 1; mst = 0; end
        else if (mst == 1 && s == SE0) mst = 2;
        mprev = (s == SE0);
        nb++;
      end
      t++;
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (active && !rst) begin
      chk(valid == e_val, "R4/R5/R11 sym_valid", valid, e_val);
      if (e_val) chk(code == e_code, "R1/R4 sym_code", code, e_code);
      chk(sop == e_sop, "R2/R3/R7 sop", sop, e_sop);
      chk(eop == e_eop, "R6 eop", eop, e_eop);
      chk(err == e_err, "R8 se1_err", err, e_err);
      chk(tmo == e_tmo, "R9 timeout", tmo, e_tmo);
      n_eop += eop; n_tmo += tmo; n_err += err; n_valid += valid;
    end
  end

  task automatic drive(int c);
    case (c)
      SE0: begin dp = 0; dm = 0; end
      SE1: begin dp = 1; dm = 1; end
      JS:  begin dp = low ? 1'b0 : 1'b1; dm = low ? 1'b1 : 1'b0; end
      default: begin dp = low ? 1'b1 : 1'b0; dm = low ? 1'b0 : 1'b1; end
    endcase
  endtask

  task automatic hold(int c, int cyc);
    drive(c);
    repeat (cyc) @(negedge clk);
  endtask

  // Bit boundaries follow the same fractional period; optional one-cycle
  // SE1 glitch at the start of each bit after the first (R5)
  task automatic packet(int seq[], bit glitch);
    int w;
    w = low ? WLS : WFS;
    for (int k = 0; k < seq.size(); k++) begin
      int len;
      len = (((k + 1) * w) >> 8) - ((k * w) >> 8);
      if (glitch && k > 0) begin
        hold(SE1, 1);
        hold(seq[k], len - 1);
      end else hold(seq[k], len);
    end
  endtask

  initial begin
    int seq_a[], seq_se1[], seq_ls[], seq_to[];
    int v0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    active = 1;
    // R10: outputs quiet right after reset
    chk(!(valid | sop | eop | err | tmo), "R10 reset outputs", {valid, sop, eop, err, tmo}, 0);
    hold(JS, 10);
    // R11: idle ignores SE0, SE1 and J
    v0 = n_valid;
    hold(SE0, 5); hold(SE1, 5); hold(JS, 8); hold(SE0, 3); hold(JS, 12);
    chk(n_valid == v0, "R11 idle samples", n_valid - v0, 0);

    seq_a = '{KS, JS, KS, KS, KS, JS, JS, KS, JS, SE0, SE0, JS};
    packet(seq_a, 0); hold(JS, 40);
    packet(seq_a, 1); hold(JS, 40);          // R5 glitches
    seq_se1 = '{KS, JS, SE1, KS, SE0, SE0, JS};
    packet(seq_se1, 0); hold(JS, 40);         // R8

    hold(SE0, 6); low = 1'b1; hold(SE0, 6); hold(JS, 300);
    seq_ls = '{KS, JS, JS, KS, SE0, SE0, JS};
    packet(seq_ls, 0); hold(JS, 300);         // R1 low-speed polarity
    hold(SE0, 6); low = 1'b0; hold(SE0, 6); hold(JS, 40);

    packet(seq_a, 0); packet(seq_a, 0); hold(JS, 40);  // R7 back to back

    seq_to = new[MAXB];
    foreach (seq_to[i]) seq_to[i] = (i % 2 == 0) ? KS : JS;
    packet(seq_to, 0); hold(JS, 60);          // R9

    chk(n_eop == 6, "R6 end-of-packet count", n_eop, 6);
    chk(n_tmo == 1, "R9 timeout count", n_tmo, 1);
    chk(n_err == 1, "R8 error count", n_err, 1);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule